// File: doc/BRIEF.md
# Memory-Resident Workspace Register Sequencer

This block supplies a processor with sixteen 16-bit general registers that are not held in flip-flops. They sit in main memory, in a sixteen-word window whose base byte address is held in a workspace pointer. The only state inside the block is the workspace pointer, the program counter and a status word. A register read, a register write or a register increment becomes a short sequence of word accesses on a 16-bit-data memory bus with a 15-bit word address. That bus has no byte select, and every access is a whole word.

The sequencer also switches the whole register context in one operation. For a hardware interrupt or a software trap it reads a two-word vector: the new workspace pointer comes first and the new program counter follows. It then stores the old pointer, program counter and status into registers 13, 14 and 15 of the new workspace, and commits the new pointer and program counter. A return operation reads those three registers back. The caller issues one command at a time with a valid strobe while the block is idle. It receives a one-cycle done pulse that carries the data of the last memory word transferred.

Top module: `wsr_seq`

## Requirements
- R1: During and after reset, busy, rsp_valid and mem_req are low, wp equals RESET_WP, pc equals RESET_PC and st is zero.
- R2: Command code 0 (register read of register n) makes one read at word address wp[15:1]+n. rsp_data returns the word read.
- R3: Command code 1 (register write) makes one write of cmd_wdata to word wp[15:1]+n. rsp_data returns the written value.
- R4: Command code 2 (increment) makes exactly three accesses in this order. The first is an instruction fetch read at word pc[15:1], after which pc advances by 2. The second is a read of register n. The third is a write of that value plus one to the same word. rsp_data is the incremented value.
- R5: After an increment, st[15] is 1 when the result is zero and st[14] equals bit 15 of the result. st[13:0] keep their old value.
- R6: Command code 3 (hardware interrupt k) reads the new workspace pointer at word 2k and the new program counter at word 2k+1.
- R7: Command code 4 (software trap k) reads its vector pair at words 2*NVEC+2k and 2*NVEC+2k+1.
- R8: After the vector reads, an interrupt or trap writes the old wp, old pc and old st to R13, R14 and R15 of the new workspace, in that order. wp and pc then take the vector values, and rsp_data is the old st.
- R9: Command code 5 (return) reads R13, R14 and R15 of the current workspace in that order and loads them into wp, pc and st. rsp_data is the restored st.
- R10: While mem_req is high and mem_ack is low, mem_addr, mem_we and mem_wdata stay unchanged. An access completes in a cycle where mem_req and mem_ack are both high.
- R11: busy rises in the cycle after a command is accepted and stays high until the final access is acknowledged. A cmd_valid that arrives while busy has no effect. rsp_valid pulses for one cycle with busy low right after the final acknowledge, and wp and st change only in that cycle.
- R12: Register word addresses wrap modulo 2^15, so a workspace near the top of memory continues at word 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, taken only while busy is low |
| cmd_op | input | 3 | Command code (0 read, 1 write, 2 increment, 3 interrupt, 4 trap, 5 return) |
| cmd_reg | input | 4 | Register number for read, write and increment |
| cmd_vec | input | $clog2(NVEC) | Vector index for interrupt and trap |
| cmd_wdata | input | 16 | Data for a register write |
| busy | output | 1 | Sequence in progress |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_data | output | 16 | Data of the last word transferred |
| wp | output | 16 | Workspace pointer (byte address) |
| pc | output | 16 | Program counter (byte address) |
| st | output | 16 | Status word |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 15 | Word address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Access acknowledge |

## Verification
Two functions can meet in one cycle. The completion of one sequence (the done pulse, with the context commit) can coincide with the acceptance of the next command. A command strobe can also arrive while an earlier sequence still owns the memory bus. The bench issues every new command on the very cycle the previous done pulse appears. It compares the next access trace and the committed wp, pc and st against a reference model, so a lost or doubled acceptance shows up as a wrong trace. It also holds a write strobe high during an increment, then checks that only three accesses occur and reads back the target register to show the write never happened.

// File: rtl/wsr_pkg.sv
package wsr_pkg;
  localparam int WORD_W = 16;
  localparam int ADDR_W = WORD_W - 1;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [ADDR_W-1:0] waddr_t;

  typedef enum logic [2:0] {
    OP_RD   = 3'd0,
    OP_WR   = 3'd1,
    OP_INC  = 3'd2,
    OP_INT  = 3'd3,
    OP_TRAP = 3'd4,
    OP_RET  = 3'd5
  } wsr_op_e;

  // Save slots in the new workspace
  localparam logic [3:0] SLOT_WP = 4'd13;
  localparam logic [3:0] SLOT_PC = 4'd14;
  localparam logic [3:0] SLOT_ST = 4'd15;

  // Word address of register n in the workspace at byte address base
  function automatic waddr_t reg_slot(word_t base, logic [3:0] n);
    return base[WORD_W-1:1] + waddr_t'(n);
  endfunction

  function automatic word_t bump(word_t v);
    return v + word_t'(1);
  endfunction

  // Zero flag in bit 15, sign flag in bit 14
  function automatic word_t flags_after(word_t old_st, word_t res);
    return {(res == '0), res[WORD_W-1], old_st[WORD_W-3:0]};
  endfunction
endpackage

// File: rtl/wsr_step_dec.sv
module wsr_step_dec
  import wsr_pkg::*;
#(
  parameter int VW = 4
) (
  input  wsr_op_e          op,
  input  logic [2:0]       step,
  input  logic [3:0]       regn,
  input  logic [VW-1:0]    vec,
  input  word_t            wp,
  input  word_t            pc,
  input  word_t            st,
  input  word_t            wdata,
  input  word_t            tmp0,
  output waddr_t           addr,
  output logic             we,
  output word_t            wd,
  output logic             last
);
  waddr_t vbase;
  assign vbase = waddr_t'({(op == OP_TRAP), vec, 1'b0});

  always_comb begin
    addr = '0;
    we   = 1'b0;
    wd   = '0;
    last = 1'b0;
    case (op)
      OP_RD: begin
        addr = reg_slot(wp, regn);
        last = 1'b1;
      end
      OP_WR: begin
        addr = reg_slot(wp, regn);
        we   = 1'b1;
        wd   = wdata;
        last = 1'b1;
      end
      OP_INC: begin
        addr = (step == 3'd0) ? pc[WORD_W-1:1] : reg_slot(wp, regn);
        if (step >= 3'd2) begin
          we   = 1'b1;
          wd   = bump(tmp0);
          last = 1'b1;
        end
      end
      OP_INT, OP_TRAP: begin
        case (step)
          3'd0: addr = vbase;
          3'd1: addr = vbase + waddr_t'(1);
          3'd2: begin addr = reg_slot(tmp0, SLOT_WP); we = 1'b1; wd = wp; end
          3'd3: begin addr = reg_slot(tmp0, SLOT_PC); we = 1'b1; wd = pc; end
          default: begin
            addr = reg_slot(tmp0, SLOT_ST);
            we   = 1'b1;
            wd   = st;
            last = 1'b1;
          end
        endcase
      end
      OP_RET: begin
        case (step)
          3'd0: addr = reg_slot(wp, SLOT_WP);
          3'd1: addr = reg_slot(wp, SLOT_PC);
          default: begin
            addr = reg_slot(wp, SLOT_ST);
            last = 1'b1;
          end
        endcase
      end
      default: last = 1'b1;
    endcase
  end
endmodule

// File: rtl/wsr_arch.sv
module wsr_arch
  import wsr_pkg::*;
#(
  parameter word_t RESET_WP = 16'h0200,
  parameter word_t RESET_PC = 16'h1000
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  pc_step,
  input  logic  ctx_load,
  input  word_t new_wp,
  input  word_t new_pc,
  input  logic  st_load,
  input  word_t new_st,
  output word_t wp,
  output word_t pc,
  output word_t st
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= RESET_WP;
      pc <= RESET_PC;
      st <= '0;
    end else begin
      if (ctx_load) begin
        wp <= new_wp;
        pc <= new_pc;
      end else if (pc_step) begin
        pc <= pc + word_t'(2);
      end
      if (st_load) st <= new_st;
    end
  end
endmodule

// File: rtl/wsr_seq.sv
module wsr_seq
  import wsr_pkg::*;
#(
  parameter int    NVEC     = 16,
  parameter word_t RESET_WP = 16'h0200,
  parameter word_t RESET_PC = 16'h1000,
  localparam int   VW       = $clog2(NVEC)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_op,
  input  logic [3:0]    cmd_reg,
  input  logic [VW-1:0] cmd_vec,
  input  logic [15:0]   cmd_wdata,
  output logic          busy,
  output logic          rsp_valid,
  output logic [15:0]   rsp_data,
  output logic [15:0]   wp,
  output logic [15:0]   pc,
  output logic [15:0]   st,
  output logic          mem_req,
  output logic          mem_we,
  output logic [14:0]   mem_addr,
  output logic [15:0]   mem_wdata,
  input  logic [15:0]   mem_rdata,
  input  logic          mem_ack
);
  logic          busy_q, done_q;
  wsr_op_e       op_q;
  logic [2:0]    step_q;
  logic [3:0]    reg_q;
  logic [VW-1:0] vec_q;
  word_t         wd_q, tmp0_q, tmp1_q, rsp_q;

  waddr_t s_addr;
  logic   s_we, s_last;
  word_t  s_wd;

  // Named internal events
  logic  accept, step_done, final_ack, pc_step, ctx_load, st_load, cap0, cap1;
  logic  is_ctx;
  word_t st_next, wp_w, pc_w, st_w;

  assign accept    = cmd_valid && !busy_q;
  assign step_done = busy_q && mem_ack;
  assign final_ack = step_done && s_last;
  assign is_ctx    = (op_q == OP_INT) || (op_q == OP_TRAP) || (op_q == OP_RET);
  assign pc_step   = step_done && (op_q == OP_INC) && (step_q == 3'd0);
  assign ctx_load  = final_ack && is_ctx;
  assign st_load   = final_ack && ((op_q == OP_INC) || (op_q == OP_RET));
  assign st_next   = (op_q == OP_RET) ? mem_rdata : flags_after(st_w, s_wd);
  assign cap0      = !s_we && (((op_q != OP_INC) && (step_q == 3'd0)) ||
                               ((op_q == OP_INC) && (step_q == 3'd1)));
  assign cap1      = !s_we && (op_q != OP_INC) && (step_q == 3'd1);

  wsr_step_dec #(.VW(VW)) u_dec (
    .op   (op_q),
    .step (step_q),
    .regn (reg_q),
    .vec  (vec_q),
    .wp   (wp_w),
    .pc   (pc_w),
    .st   (st_w),
    .wdata(wd_q),
    .tmp0 (tmp0_q),
    .addr (s_addr),
    .we   (s_we),
    .wd   (s_wd),
    .last (s_last)
  );

  wsr_arch #(.RESET_WP(RESET_WP), .RESET_PC(RESET_PC)) u_arch (
    .clk     (clk),
    .rst_n   (rst_n),
    .pc_step (pc_step),
    .ctx_load(ctx_load),
    .new_wp  (tmp0_q),
    .new_pc  (tmp1_q),
    .st_load (st_load),
    .new_st  (st_next),
    .wp      (wp_w),
    .pc      (pc_w),
    .st      (st_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      op_q   <= OP_RD;
      step_q <= '0;
      reg_q  <= '0;
      vec_q  <= '0;
      wd_q   <= '0;
      tmp0_q <= '0;
      tmp1_q <= '0;
      rsp_q  <= '0;
    end else begin
      done_q <= final_ack;
      if (accept) begin
        busy_q <= 1'b1;
        op_q   <= wsr_op_e'(cmd_op);
        step_q <= '0;
        reg_q  <= cmd_reg;
        vec_q  <= cmd_vec;
        wd_q   <= cmd_wdata;
      end else if (step_done) begin
        step_q <= step_q + 3'd1;
        if (cap0) tmp0_q <= mem_rdata;
        if (cap1) tmp1_q <= mem_rdata;
        if (s_last) begin
          busy_q <= 1'b0;
          rsp_q  <= s_we ? s_wd : mem_rdata;
        end
      end
    end
  end

  assign busy      = busy_q;
  assign rsp_valid = done_q;
  assign rsp_data  = rsp_q;
  assign wp        = wp_w;
  assign pc        = pc_w;
  assign st        = st_w;
  assign mem_req   = busy_q;
  assign mem_we    = s_we;
  assign mem_addr  = s_addr;
  assign mem_wdata = s_wd;
endmodule

// File: rtl/wsr_seq_chk.sv
module wsr_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        rsp_valid,
  input logic [15:0] wp,
  input logic [15:0] pc,
  input logic [15:0] st,
  input logic        mem_req,
  input logic        mem_we,
  input logic [14:0] mem_addr,
  input logic [15:0] mem_wdata,
  input logic        mem_ack,
  input logic        accept,
  input logic        final_ack
);
  AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R10
  AST_REQ_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy); // R11
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy); // R11
  AST_FINAL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    final_ack |=> !busy && rsp_valid); // R11
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !busy && !mem_req); // R11
  AST_WP_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wp) |-> rsp_valid); // R11
  AST_ST_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(st) |-> rsp_valid); // R5
  AST_PC_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pc) |-> busy || rsp_valid); // R4
endmodule

bind wsr_seq wsr_seq_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .rsp_valid(rsp_valid),
  .wp       (wp),
  .pc       (pc),
  .st       (st),
  .mem_req  (mem_req),
  .mem_we   (mem_we),
  .mem_addr (mem_addr),
  .mem_wdata(mem_wdata),
  .mem_ack  (mem_ack),
  .accept   (accept),
  .final_ack(final_ack)
);

// File: tb/sim_wsr_seq.sv
module sim_wsr_seq;
  localparam int          NV  = 16;
  localparam logic [15:0] RWP = 16'h0200;
  localparam logic [15:0] RPC = 16'h1000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid;
  logic [2:0]  cmd_op;
  logic [3:0]  cmd_reg;
  logic [3:0]  cmd_vec;
  logic [15:0] cmd_wdata;
  logic        busy, rsp_valid;
  logic [15:0] rsp_data, wp, pc, st;
  logic        mem_req, mem_we;
  logic [14:0] mem_addr;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata;
  logic        mem_ack;

  always #4 clk = ~clk;

  wsr_seq #(.NVEC(NV), .RESET_WP(RWP), .RESET_PC(RPC)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_reg(cmd_reg), .cmd_vec(cmd_vec), .cmd_wdata(cmd_wdata),
    .busy(busy), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .wp(wp), .pc(pc), .st(st), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ack(mem_ack)
  );

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;

  logic [15:0] mem  [int];
  logic [15:0] rmem [int];
  int tr_a[$], tr_w[$], tr_d[$];
  int ex_a[$], ex_w[$], ex_d[$];
  logic [15:0] r_wp, r_pc, r_st;

  // Memory model with random acknowledge latency; also checks R10
  int          wait_cnt;
  logic        hold_q;
  logic [14:0] h_addr;
  logic        h_we;
  logic [15:0] h_wd;

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack   <= 1'b0;
      mem_rdata <= '0;
      hold_q    <= 1'b0;
      wait_cnt   = 0;
    end else begin
      if (hold_q) begin
        n_tests++;
        if (mem_addr !== h_addr || mem_we !== h_we || mem_wdata !== h_wd) begin
          n_fail++;
          $display("FAIL R10 held access changed: act %h/%b/%h exp %h/%b/%h",
                   mem_addr, mem_we, mem_wdata, h_addr, h_we, h_wd);
        end
      end
      if (mem_req && !mem_ack) begin
        if (wait_cnt == 0) begin
          mem_ack <= 1'b1;
          hold_q  <= 1'b0;
          tr_a.push_back(int'(mem_addr));
          tr_w.push_back(int'(mem_we));
          if (mem_we) begin
            mem[int'(mem_addr)] = mem_wdata;
            tr_d.push_back(int'(mem_wdata));
          end else begin
            mem_rdata <= mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 16'h0000;
            tr_d.push_back(mem.exists(int'(mem_addr)) ? int'(mem[int'(mem_addr)]) : 0);
          end
          wait_cnt = int'($urandom % 3);
        end else begin
          wait_cnt--;
          mem_ack <= 1'b0;
          hold_q  <= 1'b1;
          h_addr  <= mem_addr;
          h_we    <= mem_we;
          h_wd    <= mem_wdata;
        end
      end else begin
        mem_ack <= 1'b0;
        hold_q  <= 1'b0;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  function automatic int rd(int a);
    return rmem.exists(a) ? int'(rmem[a]) : 0;
  endfunction

  function automatic int regw(logic [15:0] base, int n);
    return ((int'(base) >> 1) + n) % 32768;
  endfunction

  function automatic int vecw(bit trap, int k);
    return 2 * ((trap ? NV : 0) + k);
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: act %h exp %h", tag, what, act, exp);
    end
  endtask

  task automatic expect_acc(int a, int w, int d);
    ex_a.push_back(a);
    ex_w.push_back(w);
    ex_d.push_back(d);
    if (w != 0) rmem[a] = 16'(d);
  endtask

  task automatic pre(int a, logic [15:0] d);
    mem[a]  = d;
    rmem[a] = d;
  endtask

  task automatic do_cmd(string tag, int op, int n, int k, logic [15:0] wd, bit intrude);
    logic [15:0] v, res, nwp, npc, exp_rsp, o_wp, o_pc, o_st;
    int a;
    ex_a.delete(); ex_w.delete(); ex_d.delete();
    tr_a.delete(); tr_w.delete(); tr_d.delete();
    exp_rsp = '0;
    case (op)
      0: begin
        v = 16'(rd(regw(r_wp, n)));
        expect_acc(regw(r_wp, n), 0, int'(v));
        exp_rsp = v;
      end
      1: begin
        expect_acc(regw(r_wp, n), 1, int'(wd));
        exp_rsp = wd;
      end
      2: begin
        expect_acc(int'(r_pc) / 2, 0, rd(int'(r_pc) / 2));
        r_pc = r_pc + 16'd2;
        v = 16'(rd(regw(r_wp, n)));
        expect_acc(regw(r_wp, n), 0, int'(v));
        res = v + 16'd1;
        expect_acc(regw(r_wp, n), 1, int'(res));
        r_st = {(res == 16'd0), res[15], r_st[13:0]};
        exp_rsp = res;
      end
      3, 4: begin
        a   = vecw(op == 4, k);
        nwp = 16'(rd(a));
        npc = 16'(rd((a + 1) % 32768));
        expect_acc(a, 0, int'(nwp));
        expect_acc((a + 1) % 32768, 0, int'(npc));
        expect_acc(regw(nwp, 13), 1, int'(r_wp));
        expect_acc(regw(nwp, 14), 1, int'(r_pc));
        expect_acc(regw(nwp, 15), 1, int'(r_st));
        exp_rsp = r_st;
        r_wp = nwp;
        r_pc = npc;
      end
      default: begin
        o_wp = 16'(rd(regw(r_wp, 13)));
        o_pc = 16'(rd(regw(r_wp, 14)));
        o_st = 16'(rd(regw(r_wp, 15)));
        expect_acc(regw(r_wp, 13), 0, int'(o_wp));
        expect_acc(regw(r_wp, 14), 0, int'(o_pc));
        expect_acc(regw(r_wp, 15), 0, int'(o_st));
        r_wp = o_wp; r_pc = o_pc; r_st = o_st;
        exp_rsp = o_st;
      end
    endcase

    cmd_op    = 3'(op);
    cmd_reg   = 4'(n);
    cmd_vec   = 4'(k);
    cmd_wdata = wd;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    if (intrude) begin
      // R11: a write strobe during busy must be dropped
      cmd_op = 3'd1; cmd_wdata = 16'hDEAD; cmd_valid = 1'b1;
      for (int i = 0; i < 2; i++) begin
        chk("R11", "busy while sequence runs", int'(busy), 1);
        @(negedge clk);
      end
      cmd_valid = 1'b0;
    end
    while (!rsp_valid) @(negedge clk);

    chk(tag, "busy at done (R11)", int'(busy), 0);
    chk(tag, "access count", tr_a.size(), ex_a.size());
    for (int i = 0; i < ex_a.size() && i < tr_a.size(); i++) begin
      chk(tag, "access addr", tr_a[i], ex_a[i]);
      chk(tag, "access dir", tr_w[i], ex_w[i]);
      chk(tag, "access data", tr_d[i], ex_d[i]);
    end
    chk(tag, "rsp_data", int'(rsp_data), int'(exp_rsp));
    chk(tag, "wp", int'(wp), int'(r_wp));
    chk(tag, "pc", int'(pc), int'(r_pc));
    chk(tag, "st", int'(st), int'(r_st));
  endtask

  initial begin
    void'($urandom(32'd7));
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = '0; cmd_reg = '0;
    cmd_vec = '0; cmd_wdata = '0;
    r_wp = RWP; r_pc = RPC; r_st = '0;
    repeat (3) @(negedge clk);
    chk("R1", "busy", int'(busy), 0);
    chk("R1", "rsp_valid", int'(rsp_valid), 0);
    chk("R1", "mem_req", int'(mem_req), 0);
    chk("R1", "wp", int'(wp), int'(RWP));
    chk("R1", "pc", int'(pc), int'(RPC));
    chk("R1", "st", int'(st), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int k = 0; k < NV; k++) begin
      pre(vecw(0, k), 16'(16'h0100 + k * 32));
      pre(vecw(0, k) + 1, 16'(16'h4000 + k * 4));
      pre(vecw(1, k), (k == 15) ? 16'hFFF8 : 16'(16'h0800 + k * 32));
      pre(vecw(1, k) + 1, 16'(16'h6000 + k * 4));
    end

    do_cmd("R3", 1, 0, 0, 16'h1234, 0);
    do_cmd("R2", 0, 0, 0, 16'h0000, 0);
    do_cmd("R3", 1, 7, 0, 16'hFFFF, 0);
    do_cmd("R4 R5 zero", 2, 7, 0, 16'h0000, 0);
    do_cmd("R3", 1, 8, 0, 16'h7FFF, 0);
    do_cmd("R4 R5 sign", 2, 8, 0, 16'h0000, 0);
    do_cmd("R6 R8", 3, 0, 3, 16'h0000, 0);
    do_cmd("R4", 2, 2, 0, 16'h0000, 0);
    do_cmd("R9", 5, 0, 0, 16'h0000, 0);
    do_cmd("R7 R8", 4, 0, 7, 16'h0000, 0);
    do_cmd("R9", 5, 0, 0, 16'h0000, 0);
    do_cmd("R7", 4, 0, 15, 16'h0000, 0);
    do_cmd("R12 write", 1, 4, 0, 16'hABCD, 0);
    do_cmd("R12 read", 0, 4, 0, 16'h0000, 0);
    do_cmd("R9", 5, 0, 0, 16'h0000, 0);
    do_cmd("R3", 1, 5, 0, 16'h0042, 0);
    do_cmd("R11 intrude", 2, 5, 0, 16'h0000, 1);
    do_cmd("R11 readback", 0, 5, 0, 16'h0000, 0);

    for (int i = 0; i < 150; i++) begin
      do_cmd("R2-mix random", int'($urandom % 6), int'($urandom % 16),
             int'($urandom % 16), 16'($urandom), 0);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule